// File: doc/BRIEF.md
# TRS Position and ID Mismatch Detector

This block watches the timing reference sequences found in an incoming video stream and compares each one with what a free-running line/field flywheel predicts. Each sample cycle it receives two strobes. The first says that a TRS was decoded from the data, and it comes with that TRS's ID word. The second says that the flywheel expects a TRS at this position, and it comes with the ID the flywheel expects. From these two strobes the block sorts the cycle into one of three outcomes: nothing happened, the TRS was correct, or one of three kinds of fault occurred.

A fault raises a registered error flag on the very next clock edge. The flag then stays up until a TRS arrives that is correct in both position and ID. A three-bit cause vector next to the flag shows which kind of fault happened most recently.

Both outputs only carry meaning while the flywheel is running. While the enable input is low they are held at zero.

Top module: `trs_mismatch_top`

## Requirements
- R1: After synchronous reset, `trs_err` is 0 and `err_cause` is 3'b000.
- R2: With the flywheel enabled, a cycle where `fw_trs_stb` is high and `rx_trs_stb` is low is a missing-TRS fault. On the next edge `trs_err` becomes 1 and `err_cause` becomes 3'b001 (bit 0 = missing).
- R3: With the flywheel enabled, a cycle where `rx_trs_stb` is high and `fw_trs_stb` is low is a misplaced-TRS fault. On the next edge `trs_err` becomes 1 and `err_cause` becomes 3'b010 (bit 1 = misplaced).
- R4: With the flywheel enabled, a cycle where both strobes are high but `rx_trs_id` differs from `fw_trs_id` is an ID fault. On the next edge `trs_err` becomes 1 and `err_cause` becomes 3'b100 (bit 2 = wrong ID).
- R5: A fault sets the flag on the first clock edge after the faulty sample. There is exactly one register stage and no filtering.
- R6: In an enabled cycle with neither strobe high, `trs_err` and `err_cause` keep their values.
- R7: In an enabled cycle where both strobes are high and the IDs are equal, `trs_err` and `err_cause` both clear to 0 on the next edge.
- R8: In any cycle where `fw_enable` is low, both outputs go to 0 on the next edge, even if a fault is present in that same cycle.
- R9: A new fault while the flag is already set replaces `err_cause` with the new fault's one-hot code. `err_cause` never has more than one bit set.
- R10: A correct TRS while the flag is clear leaves both outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_enable | input | 1 | Flywheel running; when low the outputs are held at zero |
| rx_trs_stb | input | 1 | A TRS was decoded from the stream in this sample |
| rx_trs_id | input | ID_W | ID word of the received TRS |
| fw_trs_stb | input | 1 | The flywheel expects a TRS in this sample |
| fw_trs_id | input | ID_W | ID word the flywheel expects |
| trs_err | output | 1 | Sticky TRS error flag |
| err_cause | output | 3 | One-hot kind of the latest fault: bit 0 missing, bit 1 misplaced, bit 2 wrong ID |

## Verification
Two pairs of functions can meet in one sample. A fault can arrive in the same cycle that the flywheel enable drops, and a fault can arrive while the flag is already set from an earlier one. The bench drives a missing-TRS pattern in the same cycle it pulls `fw_enable` low, and expects zero outputs on the next edge. It also chains faults of different kinds back to back, and expects the cause vector to show only the latest kind while the flag stays high.

// File: rtl/trs_mm_pkg.sv
`timescale 1ns/1ps
package trs_mm_pkg;

    typedef enum logic [2:0] {
        EV_IDLE      = 3'd0,
        EV_GOOD      = 3'd1,
        EV_MISSING   = 3'd2,
        EV_MISPLACED = 3'd3,
        EV_BAD_ID    = 3'd4
    } trs_event_e;

    // Bit order is visible at the port: bit0 missing, bit1 misplaced, bit2 id.
    typedef struct packed {
        logic bad_id;
        logic misplaced;
        logic missing;
    } trs_cause_t;

    localparam int CAUSE_W = $bits(trs_cause_t);

    function automatic trs_cause_t cause_of(input trs_event_e ev);
        trs_cause_t c;
        c = '0;
        case (ev)
            EV_MISSING:   c.missing   = 1'b1;
            EV_MISPLACED: c.misplaced = 1'b1;
            EV_BAD_ID:    c.bad_id    = 1'b1;
            default:      c = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_fault(input trs_event_e ev);
        return (ev == EV_MISSING) || (ev == EV_MISPLACED) || (ev == EV_BAD_ID);
    endfunction

endpackage

// File: rtl/trs_event_classify.sv
`timescale 1ns/1ps
module trs_event_classify
    import trs_mm_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            rx_stb,
    input  logic [ID_W-1:0] rx_id,
    input  logic            fw_stb,
    input  logic [ID_W-1:0] fw_id,
    output trs_event_e      ev
);
    logic id_eq;

    always_comb begin
        id_eq = (rx_id == fw_id);
        unique case ({fw_stb, rx_stb})
            2'b00:   ev = EV_IDLE;
            2'b10:   ev = EV_MISSING;
            2'b01:   ev = EV_MISPLACED;
            default: ev = id_eq ? EV_GOOD : EV_BAD_ID;
        endcase
    end
endmodule

// File: rtl/trs_err_hold.sv
`timescale 1ns/1ps
module trs_err_hold
    import trs_mm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  trs_event_e ev,
    output logic       err,
    output trs_cause_t cause
);
    logic       err_nx;
    trs_cause_t cause_nx;

    always_comb begin
        err_nx   = err;
        cause_nx = cause;
        if (!enable) begin
            err_nx   = 1'b0;
            cause_nx = '0;
        end else if (is_fault(ev)) begin
            err_nx   = 1'b1;
            cause_nx = cause_of(ev);
        end else if (ev == EV_GOOD) begin
            err_nx   = 1'b0;
            cause_nx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err   <= 1'b0;
            cause <= '0;
        end else begin
            err   <= err_nx;
            cause <= cause_nx;
        end
    end

    // R9
    cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && ev == EV_IDLE) |=> ($stable(err) && $stable(cause)));

    // R9
    flag_cause_agree_chk: assert property (@(posedge clk) disable iff (rst)
        err == (cause != '0));
endmodule

// File: rtl/trs_mismatch_top.sv
`timescale 1ns/1ps
module trs_mismatch_top
    import trs_mm_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fw_enable,
    input  logic            rx_trs_stb,
    input  logic [ID_W-1:0] rx_trs_id,
    input  logic            fw_trs_stb,
    input  logic [ID_W-1:0] fw_trs_id,
    output logic            trs_err,
    output logic [2:0]      err_cause
);
    trs_event_e ev;
    trs_cause_t cause_q;

    trs_event_classify #(.ID_W(ID_W)) u_classify (
        .rx_stb (rx_trs_stb),
        .rx_id  (rx_trs_id),
        .fw_stb (fw_trs_stb),
        .fw_id  (fw_trs_id),
        .ev     (ev)
    );

    trs_err_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .enable (fw_enable),
        .ev     (ev),
        .err    (trs_err),
        .cause  (cause_q)
    );

    assign err_cause = cause_q;

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !fw_enable |=> (!trs_err && err_cause == 3'b000));

    // R2
    missing_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (fw_enable && fw_trs_stb && !rx_trs_stb) |=> (trs_err && err_cause == 3'b001));

    // R3
    misplaced_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (fw_enable && rx_trs_stb && !fw_trs_stb) |=> (trs_err && err_cause == 3'b010));

    // R4
    bad_id_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (fw_enable && rx_trs_stb && fw_trs_stb && rx_trs_id != fw_trs_id)
        |=> (trs_err && err_cause == 3'b100));

    // R7
    good_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (fw_enable && rx_trs_stb && fw_trs_stb && rx_trs_id == fw_trs_id)
        |=> (!trs_err && err_cause == 3'b000));
endmodule

// File: tb/trs_mismatch_top_bench.sv
`timescale 1ns/1ps
module trs_mismatch_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            fw_enable = 1'b0;
    logic            rx_trs_stb = 1'b0;
    logic [ID_W-1:0] rx_trs_id = '0;
    logic            fw_trs_stb = 1'b0;
    logic [ID_W-1:0] fw_trs_id = '0;
    logic            trs_err;
    logic [2:0]      err_cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic       err;
        logic [2:0] cause;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    logic       m_err   = 1'b0;
    logic [2:0] m_cause = 3'b000;

    trs_mismatch_top #(.ID_W(ID_W)) u_trs_mismatch_top (
        .clk        (clk),
        .rst        (rst),
        .fw_enable  (fw_enable),
        .rx_trs_stb (rx_trs_stb),
        .rx_trs_id  (rx_trs_id),
        .fw_trs_stb (fw_trs_stb),
        .fw_trs_id  (fw_trs_id),
        .trs_err    (trs_err),
        .err_cause  (err_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: applies one sample and pushes the expected result.
    task automatic drive(input logic en, input logic rs, input logic [ID_W-1:0] ri,
                         input logic fs, input logic [ID_W-1:0] fi, input string tag);
        exp_item_t it;
        @(negedge clk);
        fw_enable  = en;
        rx_trs_stb = rs;
        rx_trs_id  = ri;
        fw_trs_stb = fs;
        fw_trs_id  = fi;
        if (!en) begin
            m_err = 1'b0; m_cause = 3'b000;
        end else if (fs && !rs) begin
            m_err = 1'b1; m_cause = 3'b001;
        end else if (rs && !fs) begin
            m_err = 1'b1; m_cause = 3'b010;
        end else if (rs && fs && ri != fi) begin
            m_err = 1'b1; m_cause = 3'b100;
        end else if (rs && fs) begin
            m_err = 1'b0; m_cause = 3'b000;
        end
        it.err = m_err;
        it.cause = m_cause;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares just after each edge that consumed a driven sample.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (trs_err !== it.err || err_cause !== it.cause) begin
                n_fail++;
                $display("FAIL %s: got err=%b cause=%b, expected err=%b cause=%b",
                         it.tag, trs_err, err_cause, it.err, it.cause);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (trs_err !== 1'b0 || err_cause !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: got err=%b cause=%b, expected err=0 cause=000", trs_err, err_cause);
        end
        rst = 1'b0;

        drive(1, 0, 8'h00, 0, 8'h00, "R6 idle while clear");
        drive(1, 1, 8'h9D, 1, 8'h9D, "R10 good while clear");
        drive(1, 0, 8'h00, 1, 8'hB6, "R2 R5 missing TRS");
        drive(1, 0, 8'h00, 0, 8'h00, "R6 hold after missing");
        drive(1, 0, 8'h11, 0, 8'h22, "R6 hold with idle ids");
        drive(1, 0, 8'h00, 0, 8'h00, "R6 hold third idle");
        drive(1, 1, 8'h80, 0, 8'h00, "R3 R9 misplaced replaces cause");
        drive(1, 1, 8'hAB, 1, 8'hAC, "R4 R9 bad id replaces cause");
        drive(1, 1, 8'hC7, 1, 8'hC7, "R7 good clears");
        drive(1, 0, 8'h00, 0, 8'h00, "R6 idle after clear");
        drive(1, 1, 8'hFF, 1, 8'h00, "R4 bad id all bits differ");
        drive(1, 1, 8'h00, 0, 8'h00, "R3 misplaced after bad id");
        drive(1, 0, 8'h00, 1, 8'h80, "R2 missing after misplaced");
        drive(1, 1, 8'hF1, 1, 8'hF1, "R7 good clears again");
        drive(1, 1, 8'h5A, 0, 8'h00, "R3 misplaced from clear");
        drive(0, 0, 8'h00, 1, 8'hB6, "R8 disable with same-cycle missing");
        drive(0, 1, 8'h01, 1, 8'h02, "R8 bad id ignored while disabled");
        drive(0, 1, 8'h33, 0, 8'h00, "R8 misplaced ignored while disabled");
        drive(1, 0, 8'h00, 0, 8'h00, "R8 R6 idle after re-enable");
        drive(1, 1, 8'h01, 1, 8'h01, "R10 good after re-enable");
        drive(1, 1, 8'h01, 1, 8'h03, "R4 single-bit id difference");
        drive(1, 1, 8'h01, 1, 8'h03, "R4 repeated bad id");
        drive(1, 1, 8'h7E, 1, 8'h7E, "R7 good clears repeated fault");

        drive(1, 0, 8'h00, 0, 8'h00, "R6 final idle");
        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/2);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule